// File: doc/BRIEF.md
# External Bus Arbitration and Wait-State Control

This block sits beside the core on an external memory expansion port. It holds one 24-bit control word that software writes at boot. The word carries two hold bits, which can force the bus-request and bus-lock outputs on. It also carries five wait-state fields: one for each of four address areas and one for a default area. The core reports when an external access is pending, whether that access is a read-modify-write, and which area it targets. The block raises bus request, follows the grant from the external arbiter to track mastership, and then times the access. It inserts as many wait cycles as the selected field holds and pulses a done strobe at the end.

Reads of the control word return the stored bits with the ownership state spliced in at bit 21. The stored copy never holds a value at that bit. An access that has started runs to completion with the count it captured at its start, even if software rewrites the word while it runs.

Top module: `extbus_ctl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `rd_data` reads 0 and `bus_req`, `bus_lock` and `acc_done` are 0.
- R2: A write (`wr_en` high at a rising edge) updates the control word at that edge. From then on `rd_data` returns the written value in every bit except bit 21.
- R3: `rd_data[21]` reads 1 exactly when the block holds bus mastership. The value written to bit 21 has no effect.
- R4: With bit 23 of the control word set, `bus_req` is 1 even when no access is pending or running.
- R5: With bit 23 clear, `bus_req` is 1 only while `acc_req` is high or an access is in progress.
- R6: With bit 22 set, `bus_lock` is 1 even when no read-modify-write access exists.
- R7: With bit 22 clear, `bus_lock` is 1 only while a read-modify-write access (`acc_rmw` high) is requested or in progress.
- R8: Mastership is taken at a rising edge where `bus_grant` and `bus_req` are both high. It is dropped at any rising edge where `bus_grant` is low.
- R9: An access starts only at a rising edge where `acc_req` is high, the block is master, and no access or done pulse is under way. `acc_done` then goes high for exactly one cycle, following the Nth rising edge after the start edge.
- R10: N comes from the selected field. With `area_dflt` high, N is bits 20:16. Otherwise `area_sel` picks the field: 0 selects bits 4:0, 1 selects bits 9:5, 2 selects bits 12:10 and 3 selects bits 15:13. The 3-bit fields are zero-extended.
- R11: With N = 0, `acc_done` is high in the cycle that directly follows the start edge.
- R12: A write during an access does not change that access's wait count. The written value governs the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 24 | Control word write data |
| rd_data | output | 24 | Control word read value, bit 21 is ownership |
| acc_req | input | 1 | External access pending from the core |
| acc_rmw | input | 1 | Pending access is read-modify-write |
| area_sel | input | 2 | Address area of the pending access |
| area_dflt | input | 1 | Pending access uses the default area |
| bus_grant | input | 1 | Grant from the external arbiter |
| bus_req | output | 1 | Bus request |
| bus_lock | output | 1 | Bus lock |
| acc_done | output | 1 | One-cycle access completion strobe |

## Verification
`bus_req` and `bus_lock` are combinational from the hold bits, the request inputs and the busy state, so the bench checks them shortly after it drives the inputs, within the same cycle. A write, a change of ownership and the start of an access each take effect at the next rising edge. Those results are sampled at the falling edge that follows. The bench raises `acc_req` at a falling edge and counts falling edges until it sees `acc_done`. With mastership already held, that count must be N+1. A write placed two cycles into an access must not move the count.

// File: rtl/extbus_pkg.sv
package extbus_pkg;
  localparam int CFG_W     = 24;
  localparam int WAIT_W    = 5;
  localparam int NUM_AREAS = 4;
  localparam int NUM_SRC   = NUM_AREAS + 1;   // last entry is the default area
  localparam int BRH_BIT   = 23;
  localparam int BLH_BIT   = 22;
  localparam int OWN_BIT   = 21;
  localparam int SEL_W     = $clog2(NUM_AREAS);

  localparam int FLD_LSB [NUM_SRC] = '{0, 5, 10, 13, 16};
  localparam int FLD_WID [NUM_SRC] = '{5, 5, 3, 3, 5};
endpackage

// File: rtl/extbus_cfg_reg.sv
module extbus_cfg_reg
  import extbus_pkg::*;
#(
  parameter int W   = CFG_W,
  parameter int OWN = OWN_BIT
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         owner,
  output logic [W-1:0] cfg_q,
  output logic [W-1:0] rd_data
);
  localparam logic [W-1:0] WR_MASK = ~(W'(1) << OWN);

  always_ff @(posedge clk) begin
    if (rst)        cfg_q <= '0;
    else if (wr_en) cfg_q <= wr_data & WR_MASK;
  end

  always_comb begin
    rd_data      = cfg_q;
    rd_data[OWN] = owner;
  end

  // R2
  cfg_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (cfg_q == ($past(wr_data) & WR_MASK)));
endmodule

// File: rtl/extbus_arb.sv
module extbus_arb (
  input  logic clk,
  input  logic rst,
  input  logic hold_br,
  input  logic hold_bl,
  input  logic acc_req,
  input  logic acc_rmw,
  input  logic busy,
  input  logic busy_rmw,
  input  logic bus_grant,
  output logic bus_req,
  output logic bus_lock,
  output logic owner
);
  assign bus_req  = hold_br | acc_req | busy;
  assign bus_lock = hold_bl | (acc_req & acc_rmw) | (busy & busy_rmw);

  always_ff @(posedge clk) begin
    if (rst)                      owner <= 1'b0;
    else if (!bus_grant)          owner <= 1'b0;
    else if (bus_req)             owner <= 1'b1;
  end

  // R8
  own_release_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_grant |=> !owner);
  // R8
  own_take_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(owner) |-> $past(bus_grant && bus_req));
endmodule

// File: rtl/extbus_wait.sv
module extbus_wait
  import extbus_pkg::*;
#(
  parameter int W     = CFG_W,
  parameter int CNT_W = WAIT_W,
  parameter int NSEL  = SEL_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cfg,
  input  logic [NSEL-1:0] area_sel,
  input  logic         area_dflt,
  input  logic         acc_req,
  input  logic         acc_rmw,
  input  logic         owner,
  output logic         busy,
  output logic         busy_rmw,
  output logic         acc_done
);
  logic [CNT_W-1:0] fld [NUM_SRC];
  logic [CNT_W-1:0] sel_cnt;
  logic [CNT_W-1:0] cnt_q;
  logic             start;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_fld
    localparam int LSB = FLD_LSB[g];
    localparam int WID = FLD_WID[g];
    assign fld[g] = CNT_W'(cfg[LSB +: WID]);
  end

  assign sel_cnt = area_dflt ? fld[NUM_SRC-1] : fld[area_sel];
  assign start   = acc_req && owner && !busy && !acc_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      busy_rmw <= 1'b0;
      acc_done <= 1'b0;
      cnt_q    <= '0;
    end else begin
      acc_done <= 1'b0;
      if (start) begin
        busy_rmw <= acc_rmw;
        cnt_q    <= sel_cnt;
        if (sel_cnt == '0) acc_done <= 1'b1;
        else               busy     <= 1'b1;
      end else if (busy) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy     <= 1'b0;
          acc_done <= 1'b1;
        end
      end
    end
  end

  // R9
  start_owner_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(owner));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    acc_done |=> !acc_done);
  // R12
  count_down_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/extbus_ctl.sv
module extbus_ctl
  import extbus_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output logic [CFG_W-1:0] rd_data,
  input  logic             acc_req,
  input  logic             acc_rmw,
  input  logic [SEL_W-1:0] area_sel,
  input  logic             area_dflt,
  input  logic             bus_grant,
  output logic             bus_req,
  output logic             bus_lock,
  output logic             acc_done
);
  logic [CFG_W-1:0] cfg_q;
  logic owner, busy, busy_rmw;

  extbus_cfg_reg #(.W(CFG_W), .OWN(OWN_BIT)) u_cfg (
    .clk, .rst, .wr_en, .wr_data, .owner, .cfg_q, .rd_data
  );

  extbus_arb u_arb (
    .clk, .rst,
    .hold_br(cfg_q[BRH_BIT]), .hold_bl(cfg_q[BLH_BIT]),
    .acc_req, .acc_rmw, .busy, .busy_rmw, .bus_grant,
    .bus_req, .bus_lock, .owner
  );

  extbus_wait #(.W(CFG_W), .CNT_W(WAIT_W), .NSEL(SEL_W)) u_wait (
    .clk, .rst, .cfg(cfg_q), .area_sel, .area_dflt,
    .acc_req, .acc_rmw, .owner, .busy, .busy_rmw, .acc_done
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!acc_done && !bus_req && !bus_lock && rd_data == '0));
endmodule

// File: tb/test_extbus_ctl.sv
module test_extbus_ctl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [23:0] wr_data = '0;
  logic [23:0] rd_data;
  logic        acc_req = 1'b0, acc_rmw = 1'b0, area_dflt = 1'b0, bus_grant = 1'b0;
  logic [1:0]  area_sel = '0;
  logic        bus_req, bus_lock, acc_done;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  extbus_ctl i_extbus_ctl (
    .clk, .rst, .wr_en, .wr_data, .rd_data, .acc_req, .acc_rmw,
    .area_sel, .area_dflt, .bus_grant, .bus_req, .bus_lock, .acc_done
  );

  // vector: {rmw, dflt, area[1:0], count[4:0]}
  localparam logic [8:0] VEC [0:7] = '{
    {1'b0, 1'b0, 2'd0, 5'd3},
    {1'b1, 1'b0, 2'd1, 5'd17},
    {1'b0, 1'b0, 2'd2, 5'd6},
    {1'b1, 1'b0, 2'd3, 5'd7},
    {1'b0, 1'b1, 2'd0, 5'd31},
    {1'b1, 1'b1, 2'd2, 5'd0},
    {1'b0, 1'b0, 2'd1, 5'd0},
    {1'b0, 1'b0, 2'd3, 5'd1}
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] place(input int idx, input logic [4:0] val);
    int lsb [5] = '{0, 5, 10, 13, 16};
    logic [23:0] r = '0;
    for (int i = 0; i < 5; i++) r |= 24'((i == idx) ? val : 5'd2) << lsb[i];
    return r;
  endfunction

  task automatic do_write(input logic [23:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // returns falling edges from request to done; mid-write at edge count 2 if asked
  task automatic run_access(input logic rmw, input logic [1:0] ar, input logic df,
                            input logic mid, input logic [23:0] mid_d, output int lat);
    @(negedge clk);
    acc_req = 1'b1; acc_rmw = rmw; area_sel = ar; area_dflt = df;
    #1;
    check(bus_lock, rmw, "R7 lock follows rmw");
    check(bus_req, 1'b1, "R5 req during access");
    lat = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      lat++;
      if (mid && lat == 2) begin wr_en = 1'b1; wr_data = mid_d; end
      else wr_en = 1'b0;
      if (acc_done) break;
    end
    wr_en = 1'b0;
    acc_req = 1'b0; acc_rmw = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    logic [8:0] v;
    logic [23:0] cfgv;

    repeat (3) @(negedge clk);
    check(rd_data, 0, "R1 rd in reset");
    check({bus_req, bus_lock, acc_done}, 0, "R1 outputs in reset");
    rst = 1'b0;
    @(negedge clk);
    check({rd_data, bus_req, bus_lock, acc_done}, 0, "R1 after reset");

    // request without grant: no ownership, no access
    acc_req = 1'b1; #1;
    check(bus_req, 1'b1, "R5 req from acc_req");
    check(bus_lock, 1'b0, "R7 no lock without rmw");
    repeat (4) @(negedge clk);
    check(acc_done, 1'b0, "R9 no start without mastership");
    check(rd_data[21], 1'b0, "R3 not owner");
    bus_grant = 1'b1;
    @(negedge clk);
    check(rd_data[21], 1'b1, "R8 owner after grant");
    @(negedge clk);
    check(acc_done, 1'b1, "R11 zero-wait done");
    acc_req = 1'b0;
    @(negedge clk);
    check(acc_done, 1'b0, "R9 single pulse");

    // release
    bus_grant = 1'b0;
    @(negedge clk);
    check(rd_data[21], 1'b0, "R8 release on grant low");
    do_write(24'h2A5A5A);
    check(rd_data, 24'h0A5A5A, "R2 R3 readback bit21 ignored");
    check(bus_req, 1'b0, "R5 no req when idle");

    do_write(24'h800000);
    check(bus_req, 1'b1, "R4 hold request");
    check(bus_lock, 1'b0, "R7 no lock idle");
    do_write(24'h400000);
    check(bus_lock, 1'b1, "R6 hold lock");
    check(bus_req, 1'b0, "R5 req drops with hold clear");
    bus_grant = 1'b1;
    do_write(24'h800000);   // take mastership with the hold bit
    @(negedge clk);
    check(rd_data[21], 1'b1, "R3 R8 owner via hold");

    for (int i = 0; i < 8; i++) begin
      v = VEC[i];
      cfgv = place(v[6] ? 4 : int'(v[6:5] == 0 ? v[6:5] : v[6:5]), v[4:0]);
      cfgv = place(v[7] ? 4 : int'(v[6:5]), v[4:0]);
      do_write(cfgv);
      check(rd_data, cfgv | 24'h200000, "R2 field readback");
      run_access(v[8], v[6:5], v[7], 1'b0, '0, lat);
      check(lat, int'(v[4:0]) + 1, v[4:0] == 0 ? "R11 zero wait latency" : "R9 R10 wait latency");
      @(negedge clk);
      check(bus_req, 1'b0, "R5 req clear after access");
    end

    // R12: rewrite during an access
    do_write(place(0, 5'd6));
    run_access(1'b0, 2'd0, 1'b0, 1'b1, place(0, 5'd1), lat);
    check(lat, 7, "R12 count held during write");
    check(rd_data[4:0], 5'd1, "R12 write applied");
    @(negedge clk);
    run_access(1'b0, 2'd0, 1'b0, 1'b0, '0, lat);
    check(lat, 2, "R12 new count on next access");

    // lost grant blocks accesses
    bus_grant = 1'b0;
    @(negedge clk);
    acc_req = 1'b1;
    repeat (5) @(negedge clk);
    check(acc_done, 1'b0, "R9 no access after grant loss");
    check(rd_data[21], 1'b0, "R8 stays released");
    acc_req = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule